// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns one PWM reference into a complementary pair of outputs. It is meant to drive the high-side and low-side switches of a half bridge. Whenever the reference changes level, the output that is about to turn on is held inactive for a programmable number of dead-time ticks. The output that turns off does so at once. During that gap neither output is active, so the two switches are never on together.

The dead time after a rising edge is a plain tick count. The dead time after a falling edge comes from an 8-bit code held in an internal register, which is decoded into a duration. The decoding is piecewise linear with four ranges. Short delays get fine steps and long delays get coarse steps. Software loads the code through a write strobe. While a protection lock level is active, that register is frozen. Time is measured in cycles where the dead-time tick enable is high, so a slow dead-time clock can be derived outside the block.

Top module: `dt_inserter`

## Requirements
- R1: A falling-edge code with bit 7 = 0 gives a dead time equal to the code value (0 to 127 ticks).
- R2: A code with bits [7:6] = 2'b10 gives (64 + code[5:0]) × 2 ticks (128 to 254).
- R3: A code with bits [7:5] = 3'b110 gives (32 + code[4:0]) × 8 ticks (256 to 504).
- R4: A code with bits [7:5] = 3'b111 gives (32 + code[4:0]) × 16 ticks (512 to 1008).
- R5: On a rising reference edge, out_comp is low from the next clock. out_main goes high on the clock at which the rise_dt-th tick after the edge is sampled.
- R6: On a falling reference edge, out_main is low from the next clock. out_comp goes high on the clock at which the N-th tick after the edge is sampled, where N is the decoded falling-edge dead time.
- R7: The dead-time counter advances only on clocks where dt_tick is high. A tick sampled on the edge clock itself is not counted.
- R8: If the reference changes again before the dead time has elapsed, the delayed output never goes high during that pulse, and the timing restarts from the new edge.
- R9: A dead time of zero makes the delayed output go high in the same clock as the edge is taken.
- R10: A code write (code_we high) is stored only when lock_lvl is 0. At lock levels 1, 2 and 3 the write is ignored and the previous code stays in force.
- R11: After reset the falling-edge code is 0x01, and both outputs stay low until the first reference edge.
- R12: out_main and out_comp are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dt_tick | input | 1 | Dead-time tick enable |
| pwm_ref | input | 1 | PWM reference signal |
| code_wdata | input | 8 | Falling-edge dead-time code to write |
| code_we | input | 1 | Write strobe for the falling-edge code |
| rise_dt | input | RISE_W (10) | Rising-edge dead time, in ticks |
| lock_lvl | input | 2 | Protection lock level; nonzero freezes the code |
| out_main | output | 1 | Main (high-side) output |
| out_comp | output | 1 | Complementary (low-side) output |

## Verification
The hardest case to reach is a long dead time whose count runs against an irregular tick enable. The top range needs over a thousand ticks, and the count must end on exactly the right sampled tick. The bench walks each range boundary code, at 127/128, 254/256, 504/512 and 1008. In those runs the tick enable is drawn at random each cycle, and the bench counts the ticks it drives so that it knows the exact clock on which the output must rise. A reference pulse cut short before its dead time expires is set up on purpose. So are writes attempted under each lock level, and each is followed by a measured edge so the effect shows at the outputs.

// File: rtl/dt_pkg.sv
// Package: shared widths and the falling-edge code decoding for the
// dead-time inserter. Assumes an 8-bit code; the decode result fits DT_W bits.
package dt_pkg;
    localparam int CODE_W = 8;
    localparam int DT_W   = 10;   // holds the largest decoded value, 1008

    // Decode an 8-bit falling-edge code into a tick count.
    function automatic logic [DT_W-1:0] decode_fall(input logic [CODE_W-1:0] c);
        logic [DT_W-1:0] r;
        if (!c[7])
            r = DT_W'(c);
        else if (c[7:6] == 2'b10)
            r = DT_W'({1'b1, c[5:0]}) << 1;
        else if (c[7:5] == 3'b110)
            r = DT_W'({1'b1, c[4:0]}) << 3;
        else
            r = DT_W'({1'b1, c[4:0]}) << 4;
        return r;
    endfunction
endpackage

// File: rtl/dt_code_reg.sv
// Falling-edge code register. A write is accepted only while the lock level
// is zero. Assumes the write strobe is synchronous to clk. Reset value 0x01.
module dt_code_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] RESET_VAL = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   lock,
    output logic [W-1:0] code_q
);
    // Hold the code; update only on an unlocked write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= RESET_VAL;
        else if (wr_en && (lock == 2'd0))
            code_q <= wr_data;
    end
endmodule

// File: rtl/dt_fall_decode.sv
// Combinational decoder from the 8-bit falling-edge code to a tick count,
// zero-extended to the counter width. Assumes OUT_W >= dt_pkg::DT_W.
module dt_fall_decode #(
    parameter int OUT_W = dt_pkg::DT_W
) (
    input  logic [dt_pkg::CODE_W-1:0] code,
    output logic [OUT_W-1:0]          ticks
);
    // Map the four code ranges onto their durations.
    always_comb begin
        ticks = OUT_W'(dt_pkg::decode_fall(code));
    end
endmodule

// File: rtl/dt_edge_timer.sv
// Edge-driven dead-time timer. Detects reference edges against the last
// sampled value, turns the leaving output off at once, and turns the
// arriving output on after the given count of tick enables. An edge that
// arrives mid-count restarts the count. Assumes pwm_ref is synchronous.
module dt_edge_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ref_in,
    input  logic [CNT_W-1:0] rise_cnt,
    input  logic [CNT_W-1:0] fall_cnt,
    output logic             main_o,
    output logic             comp_o
);
    logic             ref_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_seen;

    // Flag a level change of the reference versus the last sample.
    always_comb edge_seen = (ref_in != ref_q);

    // Track the reference and run the dead-time count and both outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            cnt_q  <= '0;
            main_o <= 1'b0;
            comp_o <= 1'b0;
        end else if (edge_seen) begin
            ref_q <= ref_in;
            if (ref_in) begin
                comp_o <= 1'b0;
                main_o <= (rise_cnt == '0);
                cnt_q  <= rise_cnt;
            end else begin
                main_o <= 1'b0;
                comp_o <= (fall_cnt == '0);
                cnt_q  <= fall_cnt;
            end
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                if (ref_q) main_o <= 1'b1;
                else       comp_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dt_inserter.sv
// Top: complementary PWM dead-time inserter. Rising-edge dead time is a
// plain count; falling-edge dead time is an 8-bit code, lock-protected and
// decoded over four ranges. Assumes all inputs are synchronous to clk.
module dt_inserter #(
    parameter int RISE_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dt_tick,
    input  logic                      pwm_ref,
    input  logic [dt_pkg::CODE_W-1:0] code_wdata,
    input  logic                      code_we,
    input  logic [RISE_W-1:0]         rise_dt,
    input  logic [1:0]                lock_lvl,
    output logic                      out_main,
    output logic                      out_comp
);
    localparam int CNT_W = (RISE_W > dt_pkg::DT_W) ? RISE_W : dt_pkg::DT_W;

    logic [dt_pkg::CODE_W-1:0] fall_code_q;
    logic [CNT_W-1:0]          fall_ticks;
    logic [CNT_W-1:0]          rise_ticks;

    dt_code_reg #(.W(dt_pkg::CODE_W), .RESET_VAL(8'h01)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (code_we),
        .wr_data(code_wdata),
        .lock   (lock_lvl),
        .code_q (fall_code_q)
    );

    dt_fall_decode #(.OUT_W(CNT_W)) u_dec (
        .code (fall_code_q),
        .ticks(fall_ticks)
    );

    // Widen the rising-edge count to the shared counter width.
    always_comb rise_ticks = CNT_W'(rise_dt);

    dt_edge_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (dt_tick),
        .ref_in  (pwm_ref),
        .rise_cnt(rise_ticks),
        .fall_cnt(fall_ticks),
        .main_o  (out_main),
        .comp_o  (out_comp)
    );
endmodule

// File: rtl/dt_inserter_chk.sv
// Checker for dt_inserter, attached with bind. Observes the ports and the
// stored falling-edge code.
module dt_inserter_chk #(
    parameter int RISE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_ref,
    input logic              code_we,
    input logic [RISE_W-1:0] rise_dt,
    input logic [1:0]        lock_lvl,
    input logic [7:0]        fall_code,
    input logic              out_main,
    input logic              out_comp
);
    AST_NEVER_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_main && out_comp)); // R12
    AST_RISE_COMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_ref) |=> !out_comp); // R5
    AST_FALL_MAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_ref) |=> !out_main); // R6
    AST_MAIN_ON_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_main) |-> $past(pwm_ref)); // R5
    AST_COMP_ON_WITHOUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_comp) |-> !$past(pwm_ref)); // R6
    AST_ZERO_RISE_DT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwm_ref) && (rise_dt == '0)) |=> out_main); // R9
    AST_LOCKED_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (code_we && (lock_lvl != 2'd0)) |=> (fall_code == $past(fall_code))); // R10
endmodule

bind dt_inserter dt_inserter_chk #(.RISE_W(RISE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_ref  (pwm_ref),
    .code_we  (code_we),
    .rise_dt  (rise_dt),
    .lock_lvl (lock_lvl),
    .fall_code(fall_code_q),
    .out_main (out_main),
    .out_comp (out_comp)
);

// File: tb/tb_dt_inserter.sv
module tb_dt_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int RISE_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dt_tick = 1'b1;
    logic pwm_ref = 1'b0;
    logic [7:0] code_wdata = '0;
    logic code_we = 1'b0;
    logic [RISE_W-1:0] rise_dt = '0;
    logic [1:0] lock_lvl = '0;
    logic out_main, out_comp;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] cur_code = 8'h01;

    always #(CLK_PERIOD/2) clk = ~clk;

    dt_inserter #(.RISE_W(RISE_W)) dut (
        .clk(clk), .rst_n(rst_n), .dt_tick(dt_tick), .pwm_ref(pwm_ref),
        .code_wdata(code_wdata), .code_we(code_we), .rise_dt(rise_dt),
        .lock_lvl(lock_lvl), .out_main(out_main), .out_comp(out_comp)
    );

    // Expected tick count for a falling-edge code, from the requirements.
    function automatic int exp_fall(input logic [7:0] c);
        int v = int'(c);
        if (v < 128)      return v;
        else if (v < 192) return (v - 128 + 64) * 2;
        else if (v < 224) return (v - 192 + 32) * 8;
        else              return (v - 224 + 32) * 16;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic write_code(input logic [7:0] v, input logic [1:0] lk);
        code_wdata = v; code_we = 1'b1; lock_lvl = lk;
        cyc();
        code_we = 1'b0; lock_lvl = 2'd0;
        if (lk == 2'd0) cur_code = v;
    endtask

    // Apply an edge and track the delayed output tick by tick.
    task automatic run_edge(input logic nref, input int n, input bit rnd, input string req);
        int seen = 0;
        bit ok = 1;
        int at = -1;
        int cycles = 0;
        logic dly, oth;
        pwm_ref = nref;
        dt_tick = rnd ? 1'($urandom % 2) : 1'b1;
        cyc();
        dly = nref ? out_main : out_comp;
        oth = nref ? out_comp : out_main;
        if (oth !== 1'b0 || dly !== (n == 0)) begin ok = 0; at = 0; end
        while (ok && seen < n) begin
            logic t = rnd ? 1'($urandom % 2) : 1'b1;
            dt_tick = t;
            cyc();
            cycles++;
            if (t) seen++;
            dly = nref ? out_main : out_comp;
            oth = nref ? out_comp : out_main;
            if (oth !== 1'b0 || dly !== (seen >= n)) begin ok = 0; at = seen; end
        end
        check(ok, req, at, n);
        dt_tick = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 300000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); cyc(); cyc();
        rst_n = 1'b1;
        // R11: outputs idle after reset with no edge.
        for (int i = 0; i < 4; i++) begin
            cyc();
            check(out_main == 0 && out_comp == 0, "R11 idle", {out_main, out_comp}, 0);
        end
        // R11: default code 0x01 gives one tick on the fall.
        rise_dt = 3;
        run_edge(1'b1, 3, 0, "R5 rise");
        run_edge(1'b0, 1, 0, "R11 default code");

        // R9: zero dead time on both edges.
        write_code(8'h00, 2'd0);
        rise_dt = 0;
        run_edge(1'b1, 0, 0, "R9 zero rise");
        run_edge(1'b0, 0, 0, "R9 zero fall");

        // R1..R4 range boundaries, random tick enable (R7).
        rise_dt = 2;
        begin
            logic [7:0] bnd [8] = '{8'h01, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hDF, 8'hE0, 8'hFF};
            string rq [8] = '{"R1", "R1", "R2", "R2", "R3", "R3", "R4", "R4"};
            for (int i = 0; i < 8; i++) begin
                write_code(bnd[i], 2'd0);
                run_edge(1'b1, 2, 1, "R7 rise ticks");
                run_edge(1'b0, exp_fall(bnd[i]), 1, rq[i]);
            end
        end

        // R10: locked writes ignored, unlocked accepted.
        write_code(8'h05, 2'd0);
        for (int lk = 1; lk < 4; lk++) begin
            write_code(8'h40, 2'(lk));
            run_edge(1'b1, 2, 0, "R5 rise");
            run_edge(1'b0, 5, 0, "R10 locked write ignored");
        end
        write_code(8'h09, 2'd0);
        run_edge(1'b1, 2, 0, "R5 rise");
        run_edge(1'b0, 9, 0, "R10 unlocked write");

        // R8: rising pulse shorter than rise dead time.
        rise_dt = 20;
        write_code(8'h06, 2'd0);
        pwm_ref = 1'b1;
        begin
            bit ok = 1;
            for (int i = 0; i < 8; i++) begin
                cyc();
                if (out_main !== 1'b0 || out_comp !== 1'b0) ok = 0;
            end
            check(ok, "R8 short pulse main held off", out_main, 0);
        end
        run_edge(1'b0, 6, 0, "R8 restart on fall");
        // R8: falling gap shorter than fall dead time.
        write_code(8'h30, 2'd0);
        rise_dt = 4;
        run_edge(1'b1, 4, 0, "R5 rise");
        pwm_ref = 1'b0;
        begin
            bit ok = 1;
            for (int i = 0; i < 10; i++) begin
                cyc();
                if (out_comp !== 1'b0 || out_main !== 1'b0) ok = 0;
            end
            check(ok, "R8 short gap comp held off", out_comp, 0);
        end
        run_edge(1'b1, 4, 0, "R8 restart on rise");
        run_edge(1'b0, 48, 0, "R6 fall");

        // Random codes and rise counts, random ticks.
        for (int i = 0; i < 16; i++) begin
            logic [7:0] c = 8'($urandom);
            int r = int'($urandom % 40);
            write_code(c, 2'd0);
            rise_dt = RISE_W'(r);
            run_edge(1'b1, r, 1, "R5 random rise");
            run_edge(1'b0, exp_fall(c), 1, "R6 random fall");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule